// File: doc/BRIEF.md
# USB Frame Timing and Suspend Monitor

This block follows the timing of a USB device bus using events that have already been decoded. It receives a strobe for each start-of-frame token, which carries an 11-bit frame number. It also receives a high-speed flag, a bus-idle (J state) level, an end-of-reset strobe and a one-microsecond tick. From these it maintains an 11-bit frame counter and a 3-bit microframe counter. When an expected start-of-frame token is missing, a period timer supplies the event in its place.

The block also runs a small suspend state machine. It reports suspend after the bus has been idle for three frame periods. Four sticky status bits record the events. Each bit is masked by an enable input before it reaches the interrupt output, and a pulse on the matching clear input removes it.

The suspend machine has three states:
- ACTIVE: the bus is busy.
- IDLE: the bus is quiet and the microsecond count is running.
- ASLEEP: suspend has already been reported.

It has three transitions:
- *go-quiet* (ACTIVE to IDLE) happens on an idle cycle with no activity.
- *doze* (IDLE to ASLEEP) happens when the count completes, and it sets the suspend bit.
- *wake* (IDLE or ASLEEP to ACTIVE) happens on any activity: the bus leaving idle, a received token, or an end-of-reset strobe.

Top module: `usb_frame_mon`

## Requirements
- R1: After reset, `status`, `frame_num`, `micro_num`, `irq` and `speed` are all zero.
- R2: In high-speed mode, a received token whose frame number equals `frame_num` increments `micro_num` modulo 8, leaves `frame_num` unchanged, and sets status bit 1 (microframe start).
- R3: In high-speed mode, a received token whose frame number differs from `frame_num` loads `frame_num` from the token, clears `micro_num`, and sets status bit 0 (frame start).
- R4: In full-speed mode, every received token loads `frame_num`, clears `micro_num` and sets status bit 0.
- R5: In high-speed mode, when 125 `us_tick` pulses pass without a token, a microframe start is synthesized. If `micro_num` is below 7, it increments and bit 1 is set. If `micro_num` is 7, the event is a frame start instead: `frame_num` increments modulo 2048, `micro_num` becomes 0, and bit 0 is set.
- R6: In full-speed mode, when 1000 `us_tick` pulses pass without a token, `frame_num` increments modulo 2048 and bit 0 is set.
- R7: Each received token restarts the synthesis period.
- R8: Status bit 2 (suspend) is set on the 3000th `us_tick` counted while the bus stays idle. Counting starts on the cycle after the bus becomes idle.
- R9: Suspend is reported once per idle episode. Any activity (bus not idle, a token, or end of reset) restarts the count.
- R10: An `reset_done` pulse sets status bit 3 (end of reset).
- R11: `irq` is the OR of the status bits whose `irq_en` bit is set.
- R12: A 1 on `stat_clr[i]` clears status bit i. If a set of the same bit happens in the same cycle, the set wins.
- R13: `speed` reads 1 in high-speed mode and 0 in full-speed mode, one cycle after `hs_mode`.
- R14: Status bits 0 and 1 are never set in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs_mode | input | 1 | 1 = high-speed, 0 = full-speed |
| sof_valid | input | 1 | Start-of-frame token received |
| sof_frame | input | 11 | Frame number carried by the token |
| bus_idle | input | 1 | Bus is in the J (idle) state |
| reset_done | input | 1 | End-of-reset strobe |
| us_tick | input | 1 | One pulse per microsecond |
| irq_en | input | 4 | Per-bit interrupt enables |
| stat_clr | input | 4 | Write-one-to-clear pulses |
| status | output | 4 | Bit 0 frame start, bit 1 microframe start, bit 2 suspend, bit 3 end of reset |
| irq | output | 1 | Masked interrupt |
| speed | output | 1 | Speed status |
| frame_num | output | 11 | Frame counter |
| micro_num | output | 3 | Microframe counter |

## Verification
Token-driven results appear in `status`, `frame_num` and `micro_num` one cycle after the strobe. This also holds for clear pulses, end-of-reset strobes and `speed`. `irq` follows `irq_en` with no register in between.

A synthesized event lands on exactly the 125th or 1000th tick after the last token. The bench checks the cycle before that tick and then the cycle of that tick. Suspend is checked the same way, on the 2999th and 3000th counted ticks, or on the 3000th and 3001st when activity ended with a non-ticking cycle. All inputs change and all outputs are sampled at the falling edge.

// File: rtl/usb_fm_pkg.sv
package usb_fm_pkg;
    localparam int FRAME_W   = 11;
    localparam int MICRO_W   = 3;
    localparam int NSTAT     = 4;
    localparam int ST_FRAME  = 0;
    localparam int ST_MICRO  = 1;
    localparam int ST_SUSP   = 2;
    localparam int ST_EOR    = 3;

    typedef enum logic [1:0] {
        SUS_ACTIVE = 2'd0,
        SUS_IDLE   = 2'd1,
        SUS_ASLEEP = 2'd2
    } sus_state_e;

    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_MICRO = 2'd1,
        EV_FRAME = 2'd2
    } sof_evt_e;
endpackage

// File: rtl/usb_fm_timebase.sv
module usb_fm_timebase
    import usb_fm_pkg::*;
#(
    parameter int FW           = FRAME_W,
    parameter int MW           = MICRO_W,
    parameter int HS_PERIOD_US = 125,
    parameter int FS_PERIOD_US = 1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hs_mode,
    input  logic          sof_valid,
    input  logic [FW-1:0] sof_frame,
    input  logic          us_tick,
    output sof_evt_e      evt,
    output logic [FW-1:0] frame_num,
    output logic [MW-1:0] micro_num
);
    localparam int MAXP  = (HS_PERIOD_US > FS_PERIOD_US) ? HS_PERIOD_US : FS_PERIOD_US;
    localparam int CNT_W = $clog2(MAXP + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic             expire;
    logic [FW-1:0]    frame_d;
    logic [MW-1:0]    micro_d;

    always_comb begin
        limit  = hs_mode ? CNT_W'(HS_PERIOD_US - 1) : CNT_W'(FS_PERIOD_US - 1);
        expire = us_tick && (cnt_q >= limit) && !sof_valid;
    end

    // period timer: restarted by every received or synthesized start
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (sof_valid || expire) cnt_q <= '0;
        else if (us_tick)            cnt_q <= cnt_q + CNT_W'(1);
    end

    always_comb begin
        frame_d = frame_num;
        micro_d = micro_num;
        evt     = EV_NONE;
        if (sof_valid) begin
            if (hs_mode && (sof_frame == frame_num)) begin
                micro_d = micro_num + MW'(1);
                evt     = EV_MICRO;
            end else begin
                frame_d = sof_frame;
                micro_d = '0;
                evt     = EV_FRAME;
            end
        end else if (expire) begin
            if (hs_mode && (micro_num != '1)) begin
                micro_d = micro_num + MW'(1);
                evt     = EV_MICRO;
            end else begin
                frame_d = frame_num + FW'(1);
                micro_d = '0;
                evt     = EV_FRAME;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_num <= '0;
            micro_num <= '0;
        end else begin
            frame_num <= frame_d;
            micro_num <= micro_d;
        end
    end
endmodule

// File: rtl/usb_fm_suspend.sv
module usb_fm_suspend
    import usb_fm_pkg::*;
#(
    parameter int SUSPEND_US = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_idle,
    input  logic activity,
    input  logic us_tick,
    output logic susp_evt
);
    localparam int CNT_W = $clog2(SUSPEND_US + 1);

    sus_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SUS_ACTIVE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        susp_evt = 1'b0;
        unique case (state_q)
            SUS_ACTIVE: begin
                if (bus_idle && !activity) begin   // go-quiet
                    state_d = SUS_IDLE;
                    cnt_d   = '0;
                end
            end
            SUS_IDLE: begin
                if (activity) begin                // wake
                    state_d = SUS_ACTIVE;
                end else if (us_tick) begin
                    if (cnt_q == CNT_W'(SUSPEND_US - 1)) begin  // doze
                        state_d  = SUS_ASLEEP;
                        susp_evt = 1'b1;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            end
            SUS_ASLEEP: begin
                if (activity) state_d = SUS_ACTIVE; // wake
            end
            default: state_d = SUS_ACTIVE;
        endcase
    end
endmodule

// File: rtl/usb_fm_status.sv
module usb_fm_status
    import usb_fm_pkg::*;
#(
    parameter int NB = NSTAT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] set,
    input  logic [NB-1:0] clr,
    input  logic [NB-1:0] en,
    output logic [NB-1:0] stat,
    output logic          irq
);
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= (stat & ~clr) | set;   // set beats clear
    end

    always_comb irq = |(stat & en);
endmodule

// File: rtl/usb_frame_mon.sv
module usb_frame_mon
    import usb_fm_pkg::*;
#(
    parameter int HS_PERIOD_US = 125,
    parameter int FS_PERIOD_US = 1000,
    parameter int SUSPEND_US   = 3000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hs_mode,
    input  logic               sof_valid,
    input  logic [FRAME_W-1:0] sof_frame,
    input  logic               bus_idle,
    input  logic               reset_done,
    input  logic               us_tick,
    input  logic [NSTAT-1:0]   irq_en,
    input  logic [NSTAT-1:0]   stat_clr,
    output logic [NSTAT-1:0]   status,
    output logic               irq,
    output logic               speed,
    output logic [FRAME_W-1:0] frame_num,
    output logic [MICRO_W-1:0] micro_num
);
    sof_evt_e         evt;
    logic             susp_evt;
    logic             activity;
    logic [NSTAT-1:0] set_vec;

    always_comb begin
        activity          = !bus_idle || sof_valid || reset_done;
        set_vec           = '0;
        set_vec[ST_FRAME] = (evt == EV_FRAME);
        set_vec[ST_MICRO] = (evt == EV_MICRO);
        set_vec[ST_SUSP]  = susp_evt;
        set_vec[ST_EOR]   = reset_done;
    end

    usb_fm_timebase #(
        .FW(FRAME_W), .MW(MICRO_W),
        .HS_PERIOD_US(HS_PERIOD_US), .FS_PERIOD_US(FS_PERIOD_US)
    ) u_time (
        .clk(clk), .rst_n(rst_n), .hs_mode(hs_mode), .sof_valid(sof_valid),
        .sof_frame(sof_frame), .us_tick(us_tick), .evt(evt),
        .frame_num(frame_num), .micro_num(micro_num)
    );

    usb_fm_suspend #(.SUSPEND_US(SUSPEND_US)) u_susp (
        .clk(clk), .rst_n(rst_n), .bus_idle(bus_idle), .activity(activity),
        .us_tick(us_tick), .susp_evt(susp_evt)
    );

    usb_fm_status #(.NB(NSTAT)) u_stat (
        .clk(clk), .rst_n(rst_n), .set(set_vec), .clr(stat_clr), .en(irq_en),
        .stat(status), .irq(irq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) speed <= 1'b0;
        else        speed <= hs_mode;
    end
endmodule

// File: rtl/usb_frame_mon_chk.sv
module usb_frame_mon_chk
    import usb_fm_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               hs_mode,
    input logic               sof_valid,
    input logic [FRAME_W-1:0] sof_frame,
    input logic               bus_idle,
    input logic               reset_done,
    input logic [NSTAT-1:0]   irq_en,
    input logic [NSTAT-1:0]   stat_clr,
    input logic [NSTAT-1:0]   status,
    input logic               irq,
    input logic               speed,
    input logic [FRAME_W-1:0] frame_num,
    input logic [MICRO_W-1:0] micro_num
);
    assert_micro_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_valid && hs_mode && (sof_frame == frame_num))
        |=> (micro_num == $past(micro_num) + MICRO_W'(1)) && (frame_num == $past(frame_num)));

    assert_fs_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_valid && !hs_mode) |=> (frame_num == $past(sof_frame)) && (micro_num == '0));

    assert_susp_after_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[ST_SUSP]) |-> $past(bus_idle));

    assert_eor_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reset_done |=> status[ST_EOR]);

    assert_irq_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == '0) |-> !irq);

    assert_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr[ST_EOR] && !reset_done) |=> !status[ST_EOR]);

    assert_speed_R13: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (speed == $past(hs_mode)));

    assert_single_start_R14: assert property (@(posedge clk) disable iff (!rst_n)
        !($rose(status[ST_FRAME]) && $rose(status[ST_MICRO])));
endmodule

bind usb_frame_mon usb_frame_mon_chk u_chk (
    .clk(clk), .rst_n(rst_n), .hs_mode(hs_mode), .sof_valid(sof_valid),
    .sof_frame(sof_frame), .bus_idle(bus_idle), .reset_done(reset_done),
    .irq_en(irq_en), .stat_clr(stat_clr), .status(status), .irq(irq),
    .speed(speed), .frame_num(frame_num), .micro_num(micro_num)
);

// File: tb/tb_usb_frame_mon.sv
module tb_usb_frame_mon;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        hs_mode, sof_valid, bus_idle, reset_done, us_tick;
    logic [10:0] sof_frame;
    logic [3:0]  irq_en, stat_clr, status;
    logic        irq, speed;
    logic [10:0] frame_num;
    logic [2:0]  micro_num;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    usb_frame_mon dut (
        .clk(clk), .rst_n(rst_n), .hs_mode(hs_mode), .sof_valid(sof_valid),
        .sof_frame(sof_frame), .bus_idle(bus_idle), .reset_done(reset_done),
        .us_tick(us_tick), .irq_en(irq_en), .stat_clr(stat_clr), .status(status),
        .irq(irq), .speed(speed), .frame_num(frame_num), .micro_num(micro_num)
    );

    // {hs, token frame, expected frame, expected micro, expected status}
    localparam logic [29:0] VEC [8] = '{
        {1'b0, 11'd5,    11'd5,    3'd0, 4'b0001},
        {1'b1, 11'd5,    11'd5,    3'd1, 4'b0010},
        {1'b1, 11'd5,    11'd5,    3'd2, 4'b0010},
        {1'b1, 11'd6,    11'd6,    3'd0, 4'b0001},
        {1'b1, 11'd6,    11'd6,    3'd1, 4'b0010},
        {1'b0, 11'd2047, 11'd2047, 3'd0, 4'b0001},
        {1'b1, 11'd0,    11'd0,    3'd0, 4'b0001},
        {1'b1, 11'd0,    11'd0,    3'd1, 4'b0010}
    };

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    task automatic clear_all();
        us_tick  = 1'b0;
        stat_clr = 4'hF;
        cyc();
        stat_clr = 4'h0;
    endtask

    task automatic token(input logic hs, input logic [10:0] f);
        us_tick   = 1'b0;
        hs_mode   = hs;
        sof_valid = 1'b1;
        sof_frame = f;
        cyc();
        sof_valid = 1'b0;
    endtask

    task automatic ticks(input int n);
        us_tick = 1'b1;
        repeat (n) cyc();
        us_tick = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        rst_n = 1'b0; hs_mode = 1'b0; sof_valid = 1'b0; sof_frame = '0;
        bus_idle = 1'b0; reset_done = 1'b0; us_tick = 1'b0;
        irq_en = '0; stat_clr = '0;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        check("R1", "status", 32'(status), 0);
        check("R1", "frame", 32'(frame_num), 0);
        check("R1", "micro", 32'(micro_num), 0);
        check("R1", "irq/speed", {30'd0, irq, speed}, 0);

        // vector walk: received tokens (R2 R3 R4 R14)
        for (int i = 0; i < 8; i++) begin
            clear_all();
            token(VEC[i][29], VEC[i][28:18]);
            check("R2/R3/R4", $sformatf("vec%0d frame", i), 32'(frame_num), 32'(VEC[i][17:7]));
            check("R2/R3/R4", $sformatf("vec%0d micro", i), 32'(micro_num), 32'(VEC[i][6:4]));
            check("R14", $sformatf("vec%0d status", i), 32'(status), 32'(VEC[i][3:0]));
        end

        // R5: synthesized microframes in high speed
        clear_all();
        token(1'b1, 11'd6);
        check("R3", "new frame", {frame_num, 1'b0, micro_num}, {11'd6, 1'b0, 3'd0});
        clear_all();
        ticks(124);
        check("R5", "no synth before 125", 32'(micro_num), 0);
        ticks(1);
        check("R5", "synth micro", 32'(micro_num), 1);
        check("R5", "synth status", 32'(status), 32'b0010);
        ticks(6 * 125);
        check("R5", "micro at 7", {frame_num, 1'b0, micro_num}, {11'd6, 1'b0, 3'd7});
        clear_all();
        ticks(124);
        check("R5", "hold at 7", 32'(micro_num), 7);
        ticks(1);
        check("R5", "wrap frame", {frame_num, 1'b0, micro_num}, {11'd7, 1'b0, 3'd0});
        check("R14", "wrap status", 32'(status), 32'b0001);

        // R7: token restarts timer
        token(1'b1, 11'd7);
        check("R2", "micro 1", 32'(micro_num), 1);
        ticks(100);
        token(1'b1, 11'd7);
        check("R2", "micro 2", 32'(micro_num), 2);
        ticks(124);
        check("R7", "no synth after restart", 32'(micro_num), 2);
        ticks(1);
        check("R7", "synth after full period", 32'(micro_num), 3);

        // R6: full-speed synthesis with wrap
        token(1'b0, 11'd2047);
        clear_all();
        ticks(999);
        check("R6", "no synth before 1000", 32'(frame_num), 2047);
        ticks(1);
        check("R6", "frame wraps", 32'(frame_num), 0);
        check("R6", "frame status", 32'(status), 32'b0001);

        // R8 / R9: suspend
        clear_all();
        bus_idle = 1'b1;
        cyc();
        ticks(2999);
        check("R8", "no suspend at 2999", 32'(status[2]), 0);
        ticks(1);
        check("R8", "suspend at 3000", 32'(status[2]), 1);
        stat_clr = 4'b0100;
        cyc();
        stat_clr = 4'b0000;
        ticks(4000);
        check("R9", "single report", 32'(status[2]), 0);
        bus_idle = 1'b0;
        cyc();
        bus_idle = 1'b1;
        cyc();
        ticks(1500);
        token(1'b0, 11'd9);
        ticks(3000);
        check("R9", "count restarted by token", 32'(status[2]), 0);
        ticks(1);
        check("R9", "suspend after restart", 32'(status[2]), 1);
        bus_idle = 1'b0;
        cyc();

        // R10 / R11 / R12
        clear_all();
        reset_done = 1'b1;
        cyc();
        reset_done = 1'b0;
        check("R10", "eor bit", 32'(status), 32'b1000);
        check("R11", "irq masked", 32'(irq), 0);
        irq_en = 4'b1000;
        #1;
        check("R11", "irq enabled", 32'(irq), 1);
        irq_en = 4'b0111;
        #1;
        check("R11", "irq other mask", 32'(irq), 0);
        irq_en = 4'b0000;
        stat_clr = 4'b1000;
        cyc();
        stat_clr = 4'b0000;
        check("R12", "cleared", 32'(status[3]), 0);
        stat_clr = 4'b1000;
        reset_done = 1'b1;
        cyc();
        stat_clr = 4'b0000;
        reset_done = 1'b0;
        check("R12", "set wins", 32'(status[3]), 1);

        // R13
        hs_mode = 1'b1;
        cyc();
        check("R13", "speed high", 32'(speed), 1);
        hs_mode = 1'b0;
        cyc();
        check("R13", "speed full", 32'(speed), 0);

        summary();
    end
endmodule